// File: doc/BRIEF.md
# Sample Rate Ratio Estimator

The estimator watches two frame strobes, one marking input samples and one marking output samples. Both are sampled in a single fast reference clock domain. Each strobe passes through a two-flop synchronizer and a rising-edge detector. Each channel then counts reference cycles across a window of a fixed number of strobe edges. When fresh windows exist on both channels, a sequential restoring divider forms the ratio of input rate to output rate. This equals the output window length divided by the input window length.

The result is an unsigned fixed-point number with an integer part and a fractional part, held as readable status. Software that knows one of the two rates can use it to derive the other. A direction flag shows whether the output rate exceeds the input rate. An active-low ready flag reports that the measurement has settled. Ready is withdrawn again when the ratio moves or a strobe goes missing.

Top module: `srate_ratio_est`

## Requirements
- R1: After each measurement, the 16-bit result equals floor(out_cycles * 2048 / in_cycles). Here out_cycles and in_cycles are the reference-cycle spans of 256 consecutive rising edges of each strobe. ratio_int carries result bits 15:11 and ratio_frac carries bits 10:0.
- R2: When the true ratio is 32.0 or more, the result saturates to all ones: ratio_int = 31 and ratio_frac = 2047.
- R3: ratio_hi is 1 exactly when the reported ratio_int is 0, meaning the output rate is above the input rate. It is 0 otherwise, including for equal rates (ratio 1.0).
- R4: ready_n falls only on a completed measurement that lies within 2 fraction LSB of the measurement just before it.
- R5: A completed measurement that differs by more than 2 fraction LSB from the previous one drives ready_n high.
- R6: If either strobe shows no rising edge for 65536 reference cycles, ready_n goes high. This happens no earlier than 65536 cycles after that strobe's last edge, and the comparison history is cleared.
- R7: While rst_n is low and after it is released, ready_n is 1, ratio_int and ratio_frac are 0 and ratio_hi is 0.
- R8: ratio_int, ratio_frac and ratio_hi change only when a measurement completes. A strobe timeout leaves them holding the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, faster than both strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_strobe | input | 1 | Input-rate frame strobe, asynchronous, one rising edge per sample |
| out_strobe | input | 1 | Output-rate frame strobe, asynchronous, one rising edge per sample |
| ratio_int | output | 5 | Integer part of fsIN:fsOUT |
| ratio_frac | output | 11 | Fractional part of fsIN:fsOUT, LSB = 1/2048 |
| ratio_hi | output | 1 | 1 when the output rate is above the input rate |
| ready_n | output | 1 | Low once two successive measurements agree |

## Verification
The assertions assume each strobe is low for at least one reference cycle between rising edges. Under that assumption, a 256-edge window always spans at least 256 cycles and every divide sees a nonzero divisor. The bench produces single-cycle strobe pulses with periods of two cycles or more. It only changes a strobe period, or stops a strobe, at a reference clock edge. It pushes an expected ratio into the scoreboard only after every window in flight is built entirely from the new periods.

// File: rtl/srr_pkg.sv
package srr_pkg;

  localparam int CH_IN  = 0;
  localparam int CH_OUT = 1;
  localparam int CH_NUM = 2;

  // magnitude of the difference of two unsigned measurements
  function automatic int unsigned srr_absdiff(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // two measurements agree when they differ by at most tol LSB
  function automatic logic srr_agree(input int unsigned a, input int unsigned b,
                                     input int unsigned tol);
    return srr_absdiff(a, b) <= tol;
  endfunction

endpackage

// File: rtl/srr_strobe_chan.sv
module srr_strobe_chan #(
  parameter int WIN_LOG2 = 8,
  parameter int CNT_W    = 24,
  parameter int TO_CYC   = 65536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_raw,
  output logic             win_done,
  output logic [CNT_W-1:0] win_cycles,
  output logic             absent
);
  localparam int TO_W = $clog2(TO_CYC + 1);
  localparam logic [TO_W-1:0]     TO_LAST   = TO_W'(TO_CYC - 1);
  localparam logic [TO_W-1:0]     TO_CAP    = TO_W'(TO_CYC);
  localparam logic [WIN_LOG2-1:0] EDGE_LAST = '1;
  localparam logic [CNT_W-1:0]    WIN_MIN   = CNT_W'(2 ** WIN_LOG2);

  logic [2:0]          sync_sh;
  logic                edge_hit;
  logic                going_absent;
  logic [TO_W-1:0]     idle_q;
  logic                primed_q;
  logic [WIN_LOG2-1:0] edge_cnt_q;
  logic [CNT_W-1:0]    acc_q;
  logic [CNT_W-1:0]    win_q;
  logic                done_q;
  logic                absent_q;

  // two-flop synchronizer plus one history flop for the edge detector
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_sh <= '0;
    else        sync_sh <= {sync_sh[1:0], strobe_raw};
  end

  assign edge_hit     = sync_sh[1] & ~sync_sh[2];
  assign going_absent = !edge_hit && (idle_q == TO_LAST);

  // quiet-time counter, caps so that the absence pulse fires once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q   <= '0;
      absent_q <= 1'b0;
    end else begin
      absent_q <= going_absent;
      if (edge_hit)              idle_q <= '0;
      else if (idle_q != TO_CAP) idle_q <= idle_q + 1'b1;
    end
  end

  // window accumulator: acc holds cycles since the last window boundary edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q   <= 1'b0;
      edge_cnt_q <= '0;
      acc_q      <= '0;
      win_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (going_absent) begin
        primed_q   <= 1'b0;
        edge_cnt_q <= '0;
        acc_q      <= '0;
      end else if (edge_hit) begin
        if (!primed_q) begin
          primed_q   <= 1'b1;
          acc_q      <= CNT_W'(1);
          edge_cnt_q <= '0;
        end else if (edge_cnt_q == EDGE_LAST) begin
          win_q      <= acc_q;
          done_q     <= 1'b1;
          acc_q      <= CNT_W'(1);
          edge_cnt_q <= '0;
        end else begin
          acc_q      <= acc_q + 1'b1;
          edge_cnt_q <= edge_cnt_q + 1'b1;
        end
      end else if (primed_q) begin
        acc_q <= acc_q + 1'b1;
      end
    end
  end

  assign win_done   = done_q;
  assign win_cycles = win_q;
  assign absent     = absent_q;

  AST_WIN_FOLLOWS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> $past(edge_hit)); // R1
  AST_WIN_SPAN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> (win_cycles >= WIN_MIN)); // R1

endmodule

// File: rtl/srr_divider.sv
module srr_divider #(
  parameter int CNT_W  = 24,
  parameter int FRAC_W = 11,
  parameter int Q_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] num,
  input  logic [CNT_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [Q_W-1:0]   result
);
  localparam int DVD_W  = CNT_W + FRAC_W;
  localparam int STEP_W = $clog2(DVD_W + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(DVD_W - 1);

  // clamp the full-width quotient into the reported width
  function automatic logic [Q_W-1:0] clamp_quot(input logic [DVD_W-1:0] q);
    if (|q[DVD_W-1:Q_W]) return '1;
    return q[Q_W-1:0];
  endfunction

  logic              busy_q;
  logic              done_q;
  logic [STEP_W-1:0] step_q;
  logic [CNT_W:0]    rem_q;
  logic [DVD_W-1:0]  dvd_q;
  logic [DVD_W-1:0]  quo_q;
  logic [CNT_W-1:0]  den_q;
  logic [Q_W-1:0]    res_q;

  logic [CNT_W:0]    rem_sh;
  logic              fits;
  logic [CNT_W:0]    rem_nx;
  logic [DVD_W-1:0]  quo_nx;

  // one restoring step per cycle
  always_comb begin
    rem_sh = {rem_q[CNT_W-1:0], dvd_q[DVD_W-1]};
    fits   = rem_sh >= {1'b0, den_q};
    rem_nx = fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
    quo_nx = {quo_q[DVD_W-2:0], fits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      rem_q  <= '0;
      dvd_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        step_q <= '0;
        rem_q  <= '0;
        dvd_q  <= {num, {FRAC_W{1'b0}}};
        quo_q  <= '0;
        den_q  <= den;
      end else if (busy_q) begin
        rem_q  <= rem_nx;
        dvd_q  <= {dvd_q[DVD_W-2:0], 1'b0};
        quo_q  <= quo_nx;
        step_q <= step_q + 1'b1;
        if (step_q == LAST_STEP) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= clamp_quot(quo_nx);
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;

  AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R1
  AST_DIV_DEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (den != '0)); // R1

endmodule

// File: rtl/srr_lock.sv
module srr_lock
  import srr_pkg::*;
#(
  parameter int Q_W    = 16,
  parameter int FRAC_W = 11,
  parameter int TOL    = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           meas_done,
  input  logic [Q_W-1:0] meas,
  input  logic           absent_any,
  output logic [Q_W-1:0] ratio_q,
  output logic           ratio_hi,
  output logic           ready_n
);
  logic [Q_W-1:0] prev_q;
  logic           have_prev_q;
  logic [Q_W-1:0] ratio_r;
  logic           hi_r;
  logic           ready_n_r;
  logic           agree;

  assign agree = srr_agree(32'(meas), 32'(prev_q), 32'(TOL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      ratio_r     <= '0;
      hi_r        <= 1'b0;
      ready_n_r   <= 1'b1;
    end else if (absent_any) begin
      have_prev_q <= 1'b0;
      ready_n_r   <= 1'b1;
    end else if (meas_done) begin
      ratio_r     <= meas;
      hi_r        <= (meas[Q_W-1:FRAC_W] == '0);
      prev_q      <= meas;
      have_prev_q <= 1'b1;
      ready_n_r   <= !(have_prev_q && agree);
    end
  end

  assign ratio_q  = ratio_r;
  assign ratio_hi = hi_r;
  assign ready_n  = ready_n_r;

  AST_READY_AFTER_MEAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_n) |-> $past(meas_done)); // R4
  AST_DROP_ON_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    absent_any |=> ready_n); // R6
  AST_HOLD_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_done |=> ($stable(ratio_q) && $stable(ratio_hi))); // R8

endmodule

// File: rtl/srate_ratio_est.sv
module srate_ratio_est
  import srr_pkg::*;
#(
  parameter int WIN_LOG2 = 8,
  parameter int INT_W    = 5,
  parameter int FRAC_W   = 11,
  parameter int TO_CYC   = 65536,
  parameter int LOCK_TOL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_strobe,
  input  logic              out_strobe,
  output logic [INT_W-1:0]  ratio_int,
  output logic [FRAC_W-1:0] ratio_frac,
  output logic              ratio_hi,
  output logic              ready_n
);
  localparam int Q_W   = INT_W + FRAC_W;
  localparam int CNT_W = WIN_LOG2 + $clog2(TO_CYC);

  logic [CH_NUM-1:0] strobe_v;
  logic [CH_NUM-1:0] win_done_v;
  logic [CH_NUM-1:0] absent_v;
  logic [CNT_W-1:0]  win_cyc_v [CH_NUM];
  logic [CH_NUM-1:0] fresh_q;
  logic              div_start;
  logic              div_busy;
  logic              div_done;
  logic [Q_W-1:0]    div_result;
  logic [Q_W-1:0]    ratio_all;

  assign strobe_v[CH_IN]  = in_strobe;
  assign strobe_v[CH_OUT] = out_strobe;

  for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_chan
    srr_strobe_chan #(
      .WIN_LOG2(WIN_LOG2),
      .CNT_W   (CNT_W),
      .TO_CYC  (TO_CYC)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe_raw(strobe_v[ch]),
      .win_done  (win_done_v[ch]),
      .win_cycles(win_cyc_v[ch]),
      .absent    (absent_v[ch])
    );
  end

  // a divide starts once both channels hold a window not yet used
  assign div_start = (&fresh_q) && !div_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fresh_q <= '0;
    else        fresh_q <= ((fresh_q & ~{CH_NUM{div_start}}) | win_done_v) & ~absent_v;
  end

  srr_divider #(
    .CNT_W (CNT_W),
    .FRAC_W(FRAC_W),
    .Q_W   (Q_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (win_cyc_v[CH_OUT]),
    .den   (win_cyc_v[CH_IN]),
    .busy  (div_busy),
    .done  (div_done),
    .result(div_result)
  );

  srr_lock #(
    .Q_W   (Q_W),
    .FRAC_W(FRAC_W),
    .TOL   (LOCK_TOL)
  ) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .meas_done (div_done),
    .meas      (div_result),
    .absent_any(|absent_v),
    .ratio_q   (ratio_all),
    .ratio_hi  (ratio_hi),
    .ready_n   (ready_n)
  );

  assign ratio_int  = ratio_all[Q_W-1:FRAC_W];
  assign ratio_frac = ratio_all[FRAC_W-1:0];

  AST_START_NEEDS_WINDOWS: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |-> !(|absent_v)); // R6

endmodule

// File: tb/srate_ratio_est_bench.sv
module srate_ratio_est_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 198000;
  localparam int FRAC_SCALE = 2048;

  typedef struct {
    int    qi;
    int    qf;
    int    hi;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_strobe = 1'b0;
  logic       out_strobe = 1'b0;
  logic [4:0] ratio_int;
  logic [10:0] ratio_frac;
  logic       ratio_hi;
  logic       ready_n;

  int checks = 0;
  int failures = 0;
  int tin_per = 0;
  int tout_per = 0;
  int cnt_in = 0;
  int cnt_out = 0;
  exp_t sbq[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  srate_ratio_est u_srate_ratio_est (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_strobe (in_strobe),
    .out_strobe(out_strobe),
    .ratio_int (ratio_int),
    .ratio_frac(ratio_frac),
    .ratio_hi  (ratio_hi),
    .ready_n   (ready_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic exp_t expect_for(input int tin, input int tout, input string req);
    exp_t e;
    longint q;
    q = (longint'(tout) * FRAC_SCALE) / tin;
    if (q > 65535) q = 65535;
    e.qi  = int'(q / FRAC_SCALE);
    e.qf  = int'(q % FRAC_SCALE);
    e.hi  = (e.qi == 0) ? 1 : 0;
    e.req = req;
    return e;
  endfunction

  // strobe generators: single-cycle pulses, updated away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (tin_per > 0) begin
        cnt_in++;
        if (cnt_in >= tin_per) begin in_strobe = 1'b1; cnt_in = 0; end
        else in_strobe = 1'b0;
      end else in_strobe = 1'b0;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (tout_per > 0) begin
        cnt_out++;
        if (cnt_out >= tout_per) begin out_strobe = 1'b1; cnt_out = 0; end
        else out_strobe = 1'b0;
      end else out_strobe = 1'b0;
    end
  end

  // monitor: pops an expectation once the design reports ready
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && !ready_n && sbq.size() > 0) begin
        e = sbq.pop_front();
        check(int'(ratio_int) == e.qi, e.req, "ratio_int", int'(ratio_int), e.qi);
        check(int'(ratio_frac) == e.qf, e.req, "ratio_frac", int'(ratio_frac), e.qf);
        check(int'(ratio_hi) == e.hi, "R3", "ratio_hi", int'(ratio_hi), e.hi);
      end
    end
  end

  task automatic push_and_wait(input exp_t e);
    int waited = 0;
    sbq.push_back(e);
    while (sbq.size() > 0 && waited < 80000) begin
      @(negedge clk);
      waited++;
    end
    if (sbq.size() > 0) begin
      sbq.delete();
      check(1'b0, e.req, "ready_n never fell", 1, 0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tin_per = 0;
    tout_per = 0;
    cnt_in = 0;
    cnt_out = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    finish_run();
  end

  initial begin
    int waited;
    repeat (3) @(negedge clk);
    // R7: reset state, both during and right after reset
    check(ready_n == 1'b1, "R7", "ready_n in reset", int'(ready_n), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(ready_n == 1'b1, "R7", "ready_n after reset", int'(ready_n), 1);
    check(ratio_int == '0, "R7", "ratio_int after reset", int'(ratio_int), 0);
    check(ratio_frac == '0, "R7", "ratio_frac after reset", int'(ratio_frac), 0);
    check(ratio_hi == 1'b0, "R7", "ratio_hi after reset", int'(ratio_hi), 0);

    // R1 / R4: output slower than input, ratio 1.5
    tin_per = 8;
    tout_per = 12;
    push_and_wait(expect_for(8, 12, "R1"));

    // R5: rates change without reset, lock must be withdrawn
    tin_per = 12;
    tout_per = 8;
    waited = 0;
    while (ready_n == 1'b0 && waited < 30000) begin
      @(negedge clk);
      waited++;
    end
    check(ready_n == 1'b1, "R5", "ready_n after rate change", int'(ready_n), 1);
    repeat (9216) @(negedge clk);
    // R3: output faster than input
    push_and_wait(expect_for(12, 8, "R3"));

    // R1 / R3 boundary: equal rates give exactly 1.0 and flag low
    do_reset();
    tin_per = 7;
    tout_per = 7;
    push_and_wait(expect_for(7, 7, "R1"));

    // R2: ratio exactly 32.0 saturates
    do_reset();
    tin_per = 2;
    tout_per = 64;
    push_and_wait(expect_for(2, 64, "R2"));

    // R6 / R8: output strobe stops
    tout_per = 0;
    repeat (60000) @(negedge clk);
    check(ready_n == 1'b0, "R6", "ready_n before timeout", int'(ready_n), 0);
    repeat (5600) @(negedge clk);
    check(ready_n == 1'b1, "R6", "ready_n after timeout", int'(ready_n), 1);
    check(ratio_int == 5'd31, "R8", "ratio_int held", int'(ratio_int), 31);
    check(ratio_frac == 11'd2047, "R8", "ratio_frac held", int'(ratio_frac), 2047);

    finish_run();
  end

endmodule